// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block turns single read or write requests into the command stream that one DRAM bank needs. A request arrives on a valid/ready port with a flat address. The block splits that address into a row part and a column part and drives both, at different times, over one shared address bus. Commands are row-open, column read, column write and row-close. Between any two commands it waits a cycle count fixed by a parameter. One down-counter enforces all three delays.

The last row opened stays open. A later request to that row costs only a column command. A request to another row first closes the open row, then opens the new one, then issues the column command. After reset no row is open, so the first request starts with a row-open. Read data is captured from the bank a fixed delay after the column read and is handed back with a one-cycle valid strobe. The request port stays busy from acceptance until that data returns or the write delay has elapsed.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_cmd` is NOP, `rd_valid` is 0 and no row is open.
- R2: The first request after reset issues a row-open (`mem_cmd`=1) in the cycle after acceptance, carrying the row on `mem_addr`, with no row-close before it.
- R3: A column command follows its row-open by exactly T_RCD cycles and carries the column, zero-extended, on `mem_addr`.
- R4: A request to the row that is already open issues only its column command, in the cycle after acceptance.
- R5: A request to a row other than the open one issues a row-close (`mem_cmd`=4), then a row-open T_RP cycles later, then the column command T_RCD cycles after that.
- R6: A read's `rd_valid` is high for one cycle, T_CL cycles after the column read (`mem_cmd`=2), and `rd_data` equals the bank's data at that point.
- R7: A column write (`mem_cmd`=3) carries the request's data on `mem_wdata`, and `req_ready` returns T_CL cycles after it.
- R8: `req_ready` drops in the cycle after acceptance and stays low until completion; commands appear only while it is low.
- R9: `mem_cmd` uses NOP=0, ACT=1, RD=2, WR=3, PRE=4, and each command is present for one cycle.
- R10: The row is the upper ROW_W bits of `req_addr` and the column is the lower COL_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row (upper bits) and column (lower bits) |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Read data |
| mem_cmd | output | 3 | Bank command |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| mem_wdata | output | DATA_W | Data for a column write |
| mem_rdata | input | DATA_W | Data from the bank |

## Verification
Requests are played in three patterns: the first access after reset, which must open a row and close none; repeated accesses to one row, which must skip both row-open and row-close; and alternation between rows, which must close, reopen and then access, in that order. Each request's command log is compared with the expected command, cycle offset and address. Those offsets separate wrong delay loading from wrong ordering. A bench bank model applies the writes it receives. Reads that come later in another row therefore expose a misrouted column or lost data.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } dbs_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_ACT,
      ST_COL
   } dbs_state_e;
endpackage

// File: rtl/dbs_delay_timer.sv
module dbs_delay_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/dbs_open_row.sv
module dbs_open_row #(
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_en,
   input  logic             pre_en,
   input  logic [ROW_W-1:0] act_row,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             is_open,
   output logic             hit
);
   logic             open_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (act_en) begin
         open_q <= 1'b1;
         row_q  <= act_row;
      end else if (pre_en) begin
         open_q <= 1'b0;
      end
   end

   assign is_open = open_q;
   assign hit     = open_q && (row_q == cmp_row);
endmodule

// File: rtl/dbs_addr_mux.sv
module dbs_addr_mux #(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 3,
   parameter int ADDR_W = 4
) (
   input  logic              sel_row,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] row_ext, col_ext;

   generate
      if (ROW_W == ADDR_W) begin : g_row_full
         assign row_ext = row;
      end else begin : g_row_pad
         assign row_ext = {{(ADDR_W-ROW_W){1'b0}}, row};
      end
      if (COL_W == ADDR_W) begin : g_col_full
         assign col_ext = col;
      end else begin : g_col_pad
         assign col_ext = {{(ADDR_W-COL_W){1'b0}}, col};
      end
   endgenerate

   assign addr = sel_row ? row_ext : col_ext;
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 3,
   parameter int DATA_W = 8,
   parameter int T_RCD  = 3,
   parameter int T_CL   = 2,
   parameter int T_RP   = 3,
   localparam int REQ_W  = ROW_W + COL_W,
   localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [REQ_W-1:0]  req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [2:0]        mem_cmd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   import dbs_pkg::*;

   localparam int MAX_A = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int MAX_D = (MAX_A > T_CL) ? MAX_A : T_CL;
   localparam int CNT_W = $clog2(MAX_D + 1);

   generate
      if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("dram_bank_seq: widths must be at least 1");
      end
      if (T_RCD < 1 || T_CL < 1 || T_RP < 1) begin : g_bad_delay
         $error("dram_bank_seq: delays must be at least 1 cycle");
      end
   endgenerate

   dbs_state_e        state_q, state_d;
   logic              wr_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [DATA_W-1:0] wdata_q;
   dbs_cmd_e          cmd_q, cmd_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic              rdv_q;
   logic [DATA_W-1:0] rdata_q;

   logic              accept, tmr_done, tmr_load, sel_row;
   logic [CNT_W-1:0]  tmr_val;
   logic              row_open, row_hit;
   logic [ROW_W-1:0]  req_row, cur_row;
   logic [COL_W-1:0]  req_col, cur_col;
   logic              cur_wr;

   assign req_row = req_addr[REQ_W-1:COL_W];
   assign req_col = req_addr[COL_W-1:0];
   assign accept  = req_valid && (state_q == ST_IDLE);
   assign cur_row = (state_q == ST_IDLE) ? req_row   : row_q;
   assign cur_col = (state_q == ST_IDLE) ? req_col   : col_q;
   assign cur_wr  = (state_q == ST_IDLE) ? req_write : wr_q;

   dbs_delay_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
   );

   dbs_open_row #(.ROW_W(ROW_W)) u_rows (
      .clk(clk), .rst_n(rst_n),
      .act_en(cmd_d == CMD_ACT), .pre_en(cmd_d == CMD_PRE),
      .act_row(cur_row), .cmp_row(req_row),
      .is_open(row_open), .hit(row_hit)
   );

   dbs_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_amux (
      .sel_row(sel_row), .row(cur_row), .col(cur_col), .addr(addr_d)
   );

   always_comb begin
      state_d  = state_q;
      cmd_d    = CMD_NOP;
      sel_row  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (accept) begin
            tmr_load = 1'b1;
            if (row_hit) begin
               cmd_d   = req_write ? CMD_WR : CMD_RD;
               tmr_val = CNT_W'(T_CL - 1);
               state_d = ST_COL;
            end else if (row_open) begin
               cmd_d   = CMD_PRE;
               tmr_val = CNT_W'(T_RP - 1);
               state_d = ST_PRE;
            end else begin
               cmd_d   = CMD_ACT;
               sel_row = 1'b1;
               tmr_val = CNT_W'(T_RCD - 1);
               state_d = ST_ACT;
            end
         end
         ST_PRE: if (tmr_done) begin
            cmd_d    = CMD_ACT;
            sel_row  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RCD - 1);
            state_d  = ST_ACT;
         end
         ST_ACT: if (tmr_done) begin
            cmd_d    = cur_wr ? CMD_WR : CMD_RD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_CL - 1);
            state_d  = ST_COL;
         end
         ST_COL: if (tmr_done) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
         wdata_q <= '0;
         cmd_q   <= CMD_NOP;
         addr_q  <= '0;
         rdv_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         state_q <= state_d;
         cmd_q   <= cmd_d;
         rdv_q   <= 1'b0;
         if (cmd_d != CMD_NOP) addr_q <= addr_d;
         if (accept) begin
            wr_q    <= req_write;
            row_q   <= req_row;
            col_q   <= req_col;
            wdata_q <= req_wdata;
         end
         if (state_q == ST_COL && tmr_done && !wr_q) begin
            rdv_q   <= 1'b1;
            rdata_q <= mem_rdata;
         end
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rd_valid  = rdv_q;
   assign rd_data   = rdata_q;
   assign mem_cmd   = cmd_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rd_valid,
   input logic [2:0] mem_cmd
);
   import dbs_pkg::*;

   logic bank_open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         bank_open_q <= 1'b0;
      else if (mem_cmd == CMD_ACT)
         bank_open_q <= 1'b1;
      else if (mem_cmd == CMD_PRE)
         bank_open_q <= 1'b0;
   end

   assert_cmd_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd <= 3'd4);

   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_cmd_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd != CMD_NOP) |-> !req_ready);

   assert_act_on_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd == CMD_ACT) |-> !bank_open_q);

   assert_pre_on_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd == CMD_PRE) |-> bank_open_q);

   assert_col_on_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd == CMD_RD || mem_cmd == CMD_WR) |-> bank_open_q);

   assert_rdv_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
endmodule

bind dram_bank_seq dbs_checker u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rd_valid(rd_valid), .mem_cmd(mem_cmd)
);

// File: tb/dram_bank_seq_tb.sv
module dram_bank_seq_tb;
   localparam int ROW_W = 4, COL_W = 3, DATA_W = 8;
   localparam int T_RCD = 3, T_CL = 2, T_RP = 3;
   localparam int ADDR_W = 4;
   localparam int NLOC = (1 << ROW_W) * (1 << COL_W);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [ROW_W+COL_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DATA_W-1:0] rd_data, mem_wdata, mem_rdata;
   logic [2:0] mem_cmd;
   logic [ADDR_W-1:0] mem_addr;

   int checks = 0, failures = 0;
   int cycles = 0;
   logic [DATA_W-1:0] exp_q[$];
   logic [DATA_W-1:0] shadow[NLOC];
   logic [DATA_W-1:0] bank[NLOC];
   int m_row = 0, m_col = 0;
   bit tb_open = 0;
   int tb_row = 0;

   always #10 clk = ~clk;

   dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                   .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_cmd(mem_cmd),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // bench bank model: acts on commands half a cycle after they appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_cmd == 3'd1) m_row = int'(mem_addr[ROW_W-1:0]);
         if (mem_cmd == 3'd2) m_col = int'(mem_addr[COL_W-1:0]);
         if (mem_cmd == 3'd3) bank[m_row*(1<<COL_W) + int'(mem_addr[COL_W-1:0])] = mem_wdata;
      end
   end
   assign mem_rdata = bank[m_row*(1<<COL_W) + m_col];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // scoreboard monitor for read data
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(0, "R6", "unexpected rd_valid", int'(rd_data), -1);
         end else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            check(rd_data === e, "R6", "read data", int'(rd_data), int'(e));
         end
      end
   end

   task automatic do_req(input bit wr, input int row, input int col, input int wd);
      int ecmd[3], en[3], eaddr[3];
      int ne, ng, col_n, done_n;
      int gcmd[4], gn[4], gaddr[4];
      string tag;
      while (!req_ready) @(negedge clk);
      ne = 0;
      if (tb_open && tb_row == row) begin
         tag = "R4";
      end else if (tb_open) begin
         tag = "R5";
         ecmd[ne] = 4; en[ne] = 1; eaddr[ne] = -1; ne++;
         ecmd[ne] = 1; en[ne] = 1 + T_RP; eaddr[ne] = row; ne++;
      end else begin
         tag = "R2";
         ecmd[ne] = 1; en[ne] = 1; eaddr[ne] = row; ne++;
      end
      col_n = (ne == 0) ? 1 : en[ne-1] + T_RCD;
      ecmd[ne] = wr ? 3 : 2; en[ne] = col_n; eaddr[ne] = col; ne++;
      tb_open = 1; tb_row = row;
      if (wr) shadow[row*(1<<COL_W)+col] = DATA_W'(wd);
      else exp_q.push_back(shadow[row*(1<<COL_W)+col]);

      req_valid = 1'b1; req_write = wr;
      req_addr  = {ROW_W'(row), COL_W'(col)};   // R10: row upper, column lower
      req_wdata = DATA_W'(wd);
      @(negedge clk);
      req_valid = 1'b0;
      ng = 0; done_n = -1;
      for (int n = 1; n <= 60; n++) begin
         if (mem_cmd != 3'd0) begin
            if (ng < 4) begin
               gcmd[ng] = int'(mem_cmd); gn[ng] = n; gaddr[ng] = int'(mem_addr);
            end
            ng++;
            if (mem_cmd == 3'd3)
               check(mem_wdata === DATA_W'(wd), "R7", "write data on bus", int'(mem_wdata), wd);
         end
         if (req_ready) begin done_n = n; break; end
         @(negedge clk);
      end
      check(ng == ne, tag, "command count (R9)", ng, ne);
      for (int i = 0; i < 3; i++) begin
         if (i < ne && i < ng) begin
            check(gcmd[i] == ecmd[i], tag, "command code (R9)", gcmd[i], ecmd[i]);
            check(gn[i] == en[i], (ecmd[i] >= 2) ? "R3" : tag, "command cycle", gn[i], en[i]);
            if (eaddr[i] >= 0)
               check(gaddr[i] == eaddr[i], "R10", "address on bus", gaddr[i], eaddr[i]);
         end
      end
      check(done_n == col_n + T_CL, wr ? "R7" : "R8", "ready return cycle", done_n, col_n + T_CL);
   endtask

   initial begin
      for (int i = 0; i < NLOC; i++) begin
         bank[i]   = DATA_W'(i * 7 + 3);
         shadow[i] = DATA_W'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      check(mem_cmd === 3'd0, "R1", "cmd after reset", int'(mem_cmd), 0);
      check(rd_valid === 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
      do_req(0, 3, 1, 0);        // R2 closed bank
      do_req(0, 3, 5, 0);        // R4 hit
      do_req(1, 3, 5, 8'hA5);    // R4 write hit
      do_req(0, 3, 5, 0);
      do_req(1, 9, 0, 8'h3C);    // R5 miss
      do_req(0, 3, 5, 0);
      do_req(0, 9, 0, 0);
      do_req(0, 9, 7, 0);
      do_req(1, 15, 7, 8'hFF);   // boundary row/col
      do_req(0, 0, 0, 0);
      do_req(0, 15, 7, 0);
      for (int k = 0; k < 6; k++) do_req(k % 2, (k * 5) % 16, k, 8'h40 + k);
      for (int k = 0; k < 6; k++) do_req(0, (k * 5) % 16, k, 0);
      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R6", "reads outstanding", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         failures++;
         $display("FAIL watchdog R8 actual=%0d expected=%0d", cycles, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule